// File: doc/BRIEF.md
# Address-Steered Data Bit Demultiplexer

This block routes one data bit onto exactly one line of a wide output bus, chosen by a binary address, while an active-high enable is asserted. Every line that is not chosen floats at high impedance, so the bus can be wired together with other drivers that take turns placing bits onto shared configuration wiring. A second, optional bus carries the inverse of the steered bit on the same line, for storage cells that need both polarities.

The block is purely combinational, with no clock and no state. A parameter sets the number of lines. When the block has only one line, that line is driven at all times: it carries the data bit while enabled and a logic 0 otherwise. A control module turns the enable and address into a one-hot line select and a small strobe struct. A datapath module owns the tri-state drivers.

Top module: `bitsteer_demux`

## Requirements
- R1: The enable input is active high. While `enable` is 1 and the address is valid, exactly one output line is driven.
- R2: With `enable` = 1 and `NUM_LINES` > 1, line i of `dataOut` carries `dataIn` when `addr` equals i (i < NUM_LINES). It follows both 0 and 1, and every other line is high impedance.
- R3: With `NUM_LINES` > 1, an address value of NUM_LINES or more leaves every line of both output buses at high impedance, even while enabled.
- R4: With `NUM_LINES` > 1 and `enable` = 0, every line of both output buses is high impedance, whatever the address and data.
- R5: With `NUM_LINES` = 1, `dataOut[0]` equals `dataIn` while enabled and is driven to 0 while disabled. The address has no effect.
- R6: `dataOutN` is the bitwise complement of `dataOut` wherever `dataOut` is driven, and is high impedance on exactly the lines where `dataOut` is high impedance. With one line it is always driven.
- R7: The address width is ceil(log2(NUM_LINES)), with a minimum of 1 bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enable | input | 1 | Active-high enable for steering |
| addr | input | ADDR_W = max(1, ceil(log2(NUM_LINES))) | Binary index of the line to drive |
| dataIn | input | 1 | Bit placed on the selected line |
| dataOut | output | NUM_LINES | Steered bus; unselected lines high impedance |
| dataOutN | output | NUM_LINES | Inverted steered bus, with the same drive pattern |

## Verification
Every result is due in the same cycle as its stimulus, with zero registers between input and output. The bench therefore drives the inputs one time unit after a rising edge and samples one time unit later, well before the next edge. The samples are compared with case equality, so a line that should float must read exactly Z and a driven line must read exactly 0 or 1. A second instance with one line covers the single-output variant, including an address change that must not affect its output.

// File: rtl/bitsteer_pkg.sv
package bitsteer_pkg;

  // Strobes passed from the control module to the tri-state datapath.
  typedef struct packed {
    logic steer;  // a line is to be driven with the data bit
    logic park;   // single-line mode: drive a solid 0
  } steer_strobe_t;

  // Address width for a bus of n lines, never below one bit.
  function automatic int addrBits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bitsteer_ctrl.sv
module bitsteer_ctrl
  import bitsteer_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int ADDR_W    = addrBits(NUM_LINES)
) (
  input  logic                 enable,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_LINES-1:0] lineSel,
  output steer_strobe_t        strobe
);

  localparam bit SINGLE = (NUM_LINES == 1);

  generate
    if (SINGLE) begin : g_single
      always_comb begin
        lineSel[0]   = enable;
        strobe.steer = enable;
        strobe.park  = ~enable;
      end
    end else begin : g_multi
      logic inRange;
      always_comb begin
        inRange = (32'(addr) < NUM_LINES);
        for (int i = 0; i < NUM_LINES; i++) begin
          lineSel[i] = enable && (addr == ADDR_W'(i));
        end
        strobe.steer = enable && inRange;
        strobe.park  = 1'b0;
      end
    end
  endgenerate

  // The line named by the address follows the enable (R2).
  always_comb begin : chk_addr_hit
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!SINGLE && addr == ADDR_W'(i)) begin
        a_r2_addr_hit: assert (lineSel[i] == enable)
          else $error("a_r2_addr_hit: line %0d select disagrees with enable", i);
      end
    end
  end

endmodule

// File: rtl/bitsteer_datapath.sv
module bitsteer_datapath
  import bitsteer_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic [NUM_LINES-1:0] lineSel,
  input  steer_strobe_t        strobe,
  input  logic                 dataIn,
  output logic [NUM_LINES-1:0] dataOut,
  output logic [NUM_LINES-1:0] dataOutN
);

  generate
    if (NUM_LINES == 1) begin : g_single
      // One line only: drive it at all times (R5, R6).
      assign dataOut[0]  = strobe.park ? 1'b0 : (lineSel[0] & dataIn);
      assign dataOutN[0] = strobe.park ? 1'b1 : ~(lineSel[0] & dataIn);
    end else begin : g_multi
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign dataOut[i]  = lineSel[i] ? dataIn  : 1'bz;
        assign dataOutN[i] = lineSel[i] ? ~dataIn : 1'bz;
      end
    end
  endgenerate

  // Checks on the select and strobes arriving from the control module.
  always_comb begin : chk_strobes
    a_r2_onehot_select: assert ($onehot0(lineSel))
      else $error("a_r2_onehot_select: more than one line selected");
    a_r2_steer_agrees: assert (strobe.steer == (|lineSel))
      else $error("a_r2_steer_agrees: steer strobe and select disagree");
    a_r5_park_exclusive: assert (!(strobe.park && strobe.steer))
      else $error("a_r5_park_exclusive: park and steer both set");
  end

endmodule

// File: rtl/bitsteer_demux.sv
module bitsteer_demux
  import bitsteer_pkg::*;
#(
  parameter int NUM_LINES = 6,
  localparam int ADDR_W   = addrBits(NUM_LINES)
) (
  input  logic                 enable,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 dataIn,
  output logic [NUM_LINES-1:0] dataOut,
  output logic [NUM_LINES-1:0] dataOutN
);

  logic [NUM_LINES-1:0] lineSelW;
  steer_strobe_t        strobeW;

  bitsteer_ctrl #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) ctrl_i (
    .enable  (enable),
    .addr    (addr),
    .lineSel (lineSelW),
    .strobe  (strobeW)
  );

  bitsteer_datapath #(
    .NUM_LINES (NUM_LINES)
  ) dp_i (
    .lineSel  (lineSelW),
    .strobe   (strobeW),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataOutN (dataOutN)
  );

  always_comb begin : chk_top
    if (!enable) begin
      a_r4_idle_no_select: assert (lineSelW == '0 || NUM_LINES == 1)
        else $error("a_r4_idle_no_select: a line selected while disabled");
    end
    if (NUM_LINES > 1 && 32'(addr) >= NUM_LINES) begin
      a_r3_range_release: assert (lineSelW == '0)
        else $error("a_r3_range_release: out-of-range address selected a line");
    end
  end

endmodule

// File: tb/bitsteer_demux_tb_top.sv
module bitsteer_demux_tb_top;

  localparam int N  = 6;
  localparam int AW = (N <= 1) ? 1 : $clog2(N);  // R7

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic          enable;
  logic [AW-1:0] addr;
  logic          dataIn;
  wire  [N-1:0]  dataOut;
  wire  [N-1:0]  dataOutN;

  logic    enable1, addr1, dataIn1;
  wire [0:0] dataOut1, dataOutN1;

  bitsteer_demux #(.NUM_LINES(N)) dut_i (
    .enable(enable), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutN(dataOutN)
  );

  bitsteer_demux #(.NUM_LINES(1)) dut1_i (
    .enable(enable1), .addr(addr1), .dataIn(dataIn1),
    .dataOut(dataOut1), .dataOutN(dataOutN1)
  );

  // Vector layout: {enable, addr[2:0], dataIn}
  localparam int NV = 16;
  localparam logic [4:0] VEC [NV] = '{
    5'b0_000_1, 5'b1_000_1, 5'b1_001_1, 5'b1_010_1,
    5'b1_011_1, 5'b1_100_1, 5'b1_101_1, 5'b1_000_0,
    5'b1_001_0, 5'b1_010_0, 5'b1_011_0, 5'b1_100_0,
    5'b1_101_0, 5'b1_110_1, 5'b1_111_0, 5'b0_011_1
  };

  // Compare both buses of the wide instance against the expected pattern.
  task automatic checkWide(input logic en, input logic [AW-1:0] a,
                           input logic d, input string tag);
    logic [N-1:0] expP, expN;
    for (int i = 0; i < N; i++) begin
      if (en && 32'(a) == i) begin
        expP[i] = d;
        expN[i] = ~d;
      end else begin
        expP[i] = 1'bz;
        expN[i] = 1'bz;
      end
    end
    checks++;
    if (dataOut !== expP) begin
      errors++;
      $display("FAIL %s dataOut en=%0b addr=%0d din=%0b: got %b expected %b",
               tag, en, a, d, dataOut, expP);
    end
    checks++;
    if (dataOutN !== expN) begin
      errors++;
      $display("FAIL R6 dataOutN en=%0b addr=%0d din=%0b: got %b expected %b",
               en, a, d, dataOutN, expN);
    end
  endtask

  task automatic applyWide(input logic en, input logic [AW-1:0] a,
                           input logic d, input string tag);
    @(posedge clk);
    #1;
    enable = en; addr = a; dataIn = d;
    #1;  // zero-cycle path: sample well before the next edge
    checkWide(en, a, d, tag);
  endtask

  task automatic applySingle(input logic en, input logic a, input logic d);
    logic expP;
    @(posedge clk);
    #1;
    enable1 = en; addr1 = a; dataIn1 = d;
    #1;
    expP = en ? d : 1'b0;
    checks++;
    if (dataOut1[0] !== expP) begin
      errors++;
      $display("FAIL R5 single en=%0b addr=%0b din=%0b: got %b expected %b",
               en, a, d, dataOut1[0], expP);
    end
    checks++;
    if (dataOutN1[0] !== ~expP) begin
      errors++;
      $display("FAIL R6 single inverted en=%0b din=%0b: got %b expected %b",
               en, d, dataOutN1[0], ~expP);
    end
  endtask

  initial begin
    enable = 1'b0; addr = '0; dataIn = 1'b0;
    enable1 = 1'b0; addr1 = 1'b0; dataIn1 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // Reset-time state: disabled, every line floating (R4)
    checkWide(1'b0, '0, 1'b0, "R4 reset");

    for (int v = 0; v < NV; v++) begin
      logic en, d;
      logic [AW-1:0] a;
      string tag;
      {en, a, d} = VEC[v];
      if (!en)                tag = "R4 disabled";
      else if (32'(a) >= N)   tag = "R3 out-of-range";
      else                    tag = "R1 R2 steer";
      applyWide(en, a, d, tag);
    end

    // Corner cases on the wide bus
    applyWide(1'b1, AW'(N - 1), 1'b1, "R2 top line");
    applyWide(1'b1, AW'(N - 1), 1'b0, "R2 top line data 0");
    applyWide(1'b0, AW'(N - 1), 1'b1, "R4 disable top line");
    applyWide(1'b1, AW'(N), 1'b1, "R3 first invalid code");

    // Single-line variant (R5): the address must have no effect
    applySingle(1'b1, 1'b0, 1'b1);
    applySingle(1'b1, 1'b0, 1'b0);
    applySingle(1'b0, 1'b0, 1'b1);
    applySingle(1'b1, 1'b1, 1'b1);
    applySingle(1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule